// File: doc/BRIEF.md
# Run-Length Echo of Ones

This block watches a serial bit stream and measures every run of consecutive ones on it. When the stream returns to zero, the block plays the run back as a burst of ones on its output. The burst starts in the clock where the first zero arrives and lasts as many clocks as the run had ones. At all other times the output is zero.

One up/down counter holds the run length. It counts up while ones arrive and counts down while the burst plays. A single replay flag keeps the burst going once it has started. While the flag is set, the input is not looked at, so a run that begins during a burst is lost. The counter stops at its top value, which is 15 with the default 4-bit width. A longer run is therefore echoed as a 15-clock burst.

Top module: `runecho_top`

## Requirements
- R1: After reset the counter is zero and no replay is pending, so holding `bitIn` at 0 keeps `echoOut` at 0.
- R2: While no burst is playing and `bitIn` is 1, `echoOut` is 0 and the stored run length grows by one each clock.
- R3: In the first clock where `bitIn` is 0 after a run, `echoOut` is 1 in that same clock. The output is a combinational function of `bitIn` and the registered state.
- R4: A run of N ones, with N between 1 and 15, produces exactly N consecutive clocks with `echoOut` = 1, followed by 0.
- R5: A run longer than 15 ones is held at a count of 15 and produces a burst of exactly 15 ones.
- R6: While a burst is playing, `bitIn` is ignored. Ones that arrive during the burst neither lengthen it nor start a new count, so a 0 in the clock after the burst gives `echoOut` = 0.
- R7: When no burst is playing, `bitIn` is 0 and the count is zero, `echoOut` is 0 and the count stays at zero.
- R8: The burst ends in the clock where the count steps down from 1, and that clock still carries `echoOut` = 1. A run that starts in the next clock is counted from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the counter and the replay flag |
| bitIn | input | 1 | Serial input stream whose runs of ones are measured |
| echoOut | output | 1 | Burst output; 1 for as many clocks as the last run had ones |

## Verification
The properties assume that `bitIn` is a clean synchronous value that is stable around each rising edge. They also assume that reset is held for at least one edge before checking begins. The bench meets this by changing `bitIn` only on the falling edge and by keeping reset high over several edges at the start. The counting properties also assume that the counter can only step when the control asks it to. The stimulus covers this case by driving long runs that press against the saturation limit, and by driving ones during every burst.

// File: rtl/runecho_pkg.sv
package runecho_pkg;

  // Control requests sent to the datapath each clock.
  typedef struct packed {
    logic cntUp;
    logic cntDown;
    logic setReplay;
    logic clrReplay;
  } echoStrobes_t;

  // Datapath state summary seen by the control.
  typedef struct packed {
    logic isZero;
    logic isOne;
    logic isFull;
    logic replay;
  } echoStatus_t;

endpackage

// File: rtl/runecho_datapath.sv
module runecho_datapath
  import runecho_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  echoStrobes_t     strobes,
  output echoStatus_t      status,
  output logic [CNT_W-1:0] cntVal
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] runCnt;
  logic             replayQ;

  // Up/down run-length counter
  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
    end else if (strobes.cntUp) begin
      runCnt <= runCnt + CNT_ONE;
    end else if (strobes.cntDown) begin
      runCnt <= runCnt - CNT_ONE;
    end
  end

  // Replay lockout flag
  always_ff @(posedge clk) begin
    if (rst) begin
      replayQ <= 1'b0;
    end else if (strobes.setReplay) begin
      replayQ <= 1'b1;
    end else if (strobes.clrReplay) begin
      replayQ <= 1'b0;
    end
  end

  always_comb begin
    status.isZero = (runCnt == '0);
    status.isOne  = (runCnt == CNT_ONE);
    status.isFull = (runCnt == CNT_MAX);
    status.replay = replayQ;
  end

  assign cntVal = runCnt;

  // R2: the control never asks for both directions at once
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.cntUp, strobes.cntDown}));

  // R8: set and clear of the replay flag never coincide
  replay_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(strobes.setReplay && strobes.clrReplay));

endmodule

// File: rtl/runecho_ctrl.sv
module runecho_ctrl
  import runecho_pkg::*;
(
  input  logic         bitIn,
  input  echoStatus_t  status,
  output echoStrobes_t strobes,
  output logic         echoOut
);

  always_comb begin
    strobes = '0;
    echoOut = 1'b0;
    if (status.replay) begin
      // Burst in progress: input ignored, count down to empty
      echoOut         = 1'b1;
      strobes.cntDown = 1'b1;
      if (status.isOne) begin
        strobes.clrReplay = 1'b1;
      end
    end else if (bitIn) begin
      // Run in progress: count up, hold at the top value
      if (!status.isFull) begin
        strobes.cntUp = 1'b1;
      end
    end else if (!status.isZero) begin
      // First zero after a run: start the burst in this clock
      echoOut         = 1'b1;
      strobes.cntDown = 1'b1;
      if (!status.isOne) begin
        strobes.setReplay = 1'b1;
      end
    end
  end

endmodule

// File: rtl/runecho_top.sv
module runecho_top
  import runecho_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bitIn,
  output logic echoOut
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  echoStrobes_t     strobes;
  echoStatus_t      status;
  logic [CNT_W-1:0] cntVal;

  runecho_ctrl u_ctrl (
    .bitIn   (bitIn),
    .status  (status),
    .strobes (strobes),
    .echoOut (echoOut)
  );

  runecho_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .status  (status),
    .cntVal  (cntVal)
  );

  // R2: a one with room left raises the count by one and keeps the output low
  count_up_chk: assert property (@(posedge clk) disable iff (rst)
    (bitIn && !status.replay && cntVal != CNT_MAX) |-> !echoOut ##1 (cntVal == $past(cntVal) + CNT_ONE));

  // R5: a full count with more ones is held
  saturate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bitIn && !status.replay && cntVal == CNT_MAX) |=> (cntVal == CNT_MAX));

  // R6: during a burst the output stays high and the count falls whatever the input
  replay_drain_chk: assert property (@(posedge clk) disable iff (rst)
    status.replay |-> echoOut ##1 (cntVal == $past(cntVal) - CNT_ONE));

  // R7: idle with an empty count gives no output and no change
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!bitIn && !status.replay && cntVal == '0) |-> !echoOut ##1 (cntVal == '0));

  // R8: the burst ends once the count leaves 1
  replay_end_chk: assert property (@(posedge clk) disable iff (rst)
    (status.replay && cntVal == CNT_ONE) |=> (!status.replay && cntVal == '0));

  // R3: a zero after a stored run drives the output in that clock
  first_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!bitIn && cntVal != '0) |-> echoOut);

endmodule

// File: tb/runecho_top_bench.sv
module runecho_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXRUN = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitIn = 1'b0;
  logic echoOut;

  int nChecks = 0;
  int nFails = 0;
  int refRun = 0;
  int refPend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  runecho_top u_runecho_top (
    .clk     (clk),
    .rst     (rst),
    .bitIn   (bitIn),
    .echoOut (echoOut)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: echoOut=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // One clock: drive after the falling edge, compare, then step the model.
  task automatic step(input logic v, input string tag);
    logic expZ;
    @(negedge clk);
    bitIn = v;
    #1;
    if (refPend > 0) begin
      expZ = 1'b1;
      refPend--;
    end else if (v) begin
      expZ = 1'b0;
      if (refRun < MAXRUN) refRun++;
    end else if (refRun > 0) begin
      expZ = 1'b1;
      refPend = refRun - 1;
      refRun = 0;
    end else begin
      expZ = 1'b0;
    end
    check(echoOut, expZ, tag);
  endtask

  task automatic doReset();
    rst = 1'b1;
    bitIn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    refRun = 0;
    refPend = 0;
  endtask

  // R1 R7: quiet after reset
  task automatic testReset();
    doReset();
    for (int i = 0; i < 4; i++) step(1'b0, "R1/R7 idle after reset");
  endtask

  // R2 R3: the fixed example stream
  task automatic testTrace();
    logic [23:0] xs = 24'b000100001111000000011000;
    logic [23:0] zs = 24'b000010000000111100000110;
    for (int i = 23; i >= 0; i--) begin
      step(xs[i], "R3 trace");
      check(echoOut, zs[i], "R2/R3 trace literal");
    end
  endtask

  // R4 R5: burst length per run length; counts the ones on the output
  task automatic testRun(input int n);
    int ones = 0;
    int expOnes;
    for (int i = 0; i < n; i++) step(1'b1, "R2 run");
    for (int i = 0; i < n + 3; i++) begin
      step(1'b0, "R4 burst");
      if (echoOut === 1'b1) ones++;
    end
    expOnes = (n > MAXRUN) ? MAXRUN : n;
    nChecks++;
    if (ones != expOnes) begin
      nFails++;
      $display("FAIL %s: burst=%0d expected=%0d", (n > MAXRUN) ? "R5" : "R4", ones, expOnes);
    end
  endtask

  // R6: ones during a burst are dropped
  task automatic testLockout();
    for (int i = 0; i < 4; i++) step(1'b1, "R6 run");
    step(1'b0, "R6 burst start");
    for (int i = 0; i < 3; i++) step(1'b1, "R6 ones ignored in burst");
    step(1'b0, "R6 no echo after burst");
    check(echoOut, 1'b0, "R6 lost run");
  endtask

  // R8: a run starting the clock after a burst ends is counted from zero
  task automatic testBackToBack();
    for (int i = 0; i < 2; i++) step(1'b1, "R8 run a");
    step(1'b0, "R8 burst a");
    step(1'b0, "R8 burst a last");
    step(1'b1, "R8 run b");
    step(1'b1, "R8 run b");
    step(1'b1, "R8 run b");
    step(1'b0, "R8 burst b");
    check(echoOut, 1'b1, "R8 new burst starts");
    for (int i = 0; i < 4; i++) step(1'b0, "R8 drain");
  endtask

  // R4 R5 R6: random stream with long runs
  task automatic testRandom();
    int len;
    for (int k = 0; k < 300; k++) begin
      len = $urandom_range(0, 22);
      for (int i = 0; i < len; i++) step(1'b1, "R5 random run");
      len = $urandom_range(0, 20);
      for (int i = 0; i < len; i++) step(1'b0, "R4 random gap");
    end
  endtask

  initial begin
    testReset();
    testTrace();
    testRun(1);
    testRun(7);
    testRun(15);
    testRun(16);
    testRun(20);
    testLockout();
    testBackToBack();
    testRandom();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule